// File: doc/BRIEF.md
# Lockstep Sample Rate Counter

This block produces the sample/conversion strobe for one codec channel from the serial bit clock. The bit clock is first divided by a fixed prescale of 32. The prescaled ticks then step a down-counter that runs over a programmable modulus. Each time the counter runs out, the block emits a one-clock strobe and reloads the modulus. The sample rate is therefore the bit clock divided by 32 times the modulus.

A matching counter sits on the far side of the serial link, and both must advance together. For that reason an enabled channel does not count straight away. It arms, and begins decrementing only at the first frame-sync pulse that arrives after the enable. The modulus is reloaded on three events: when the channel is enabled, when software writes the modulus while the channel is enabled, and when the count runs out. One instance serves audio (modulus 9 to 127) and one serves telecom (modulus 16 to 127). The two instances differ only in the lower bound parameter.

Top module: `sampleRateCounter`

## Requirements
- R1: While running, the count decrements once every 32 bit clocks. The prescaler is cleared on enable, so the first decrement happens at the 32nd rising edge after the edge that samples the starting sync pulse.
- R2: A modulus write is clamped to the legal range [MOD_MIN, 127]. A value below the range stores MOD_MIN and a value above it stores 127. The defaults are MOD_MIN 9 for audio and 16 for telecom.
- R3: On the first enabled edge after being disabled, the count (`sampleCount`, binary) loads the programmed modulus.
- R4: After enable, decrementing starts only at the first edge that samples `syncPulse` high while armed. A sync pulse on the enabling edge itself does not start counting. Sync pulses while running have no effect.
- R5: When the count is 1 and a prescaled tick occurs, `sampleStrobe` is high for exactly one clock after that edge and the count reloads the modulus. The strobe period is therefore 32 × modulus clocks.
- R6: A modulus write while enabled loads the clamped value into the count on that edge, taking priority over a decrement. It leaves the prescaler phase alone. If the write meets a tick with the count at 1, the strobe is still produced.
- R7: While disabled, the count is held and no strobe is produced. A write while disabled changes only the stored modulus.
- R8: After reset, `sampleStrobe` is 0, `sampleCount` is 0, the channel is idle and the stored modulus is MOD_MIN.
- R9: On the telecom instance with modulus 40, strobes are spaced exactly 1280 bit clocks apart. At a 9.216 MHz bit clock this gives 7.2 kHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable level |
| syncPulse | input | 1 | Frame sync, one clock wide |
| modWe | input | 1 | Modulus write strobe |
| modData | input | DATA_W (8) | Modulus write value, clamped |
| sampleCount | output | CNT_W (7) | Current count, binary |
| sampleStrobe | output | 1 | One-clock sample strobe |

## Verification
A modulus write can land in the same cycle as the prescaled tick that takes the count to zero, so the write-reload and the zero-reload compete. The bench restarts the channel with a known modulus. It then places the write exactly on edge 32 × modulus after the starting sync. It expects the strobe to fire and the count to take the newly written value rather than the old modulus. The spacing that follows must match the new value.

// File: rtl/srcPkg.sv
`timescale 1ns/1ps
package srcPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} runState_e;

  typedef struct packed {
    logic reloadCnt;  // channel just enabled
    logic modWrite;   // store a new modulus
    logic loadWrite;  // write while enabled: load count
    logic tick;       // prescaled tick while running
  } ctlStrobes_t;
endpackage

// File: rtl/srcCtrl.sv
`timescale 1ns/1ps
module srcCtrl
  import srcPkg::*;
#(
  parameter int PRESCALE = 32,
  localparam int PRE_W = $clog2(PRESCALE)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        syncPulse,
  input  logic        modWe,
  output ctlStrobes_t ctl
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  runState_e  stateQ, stateD;
  logic [PRE_W-1:0] preQ;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:  if (enable) stateD = ST_ARMED;
      ST_ARMED: if (!enable) stateD = ST_IDLE;
                else if (syncPulse) stateD = ST_RUN;
      ST_RUN:   if (!enable) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      preQ   <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE && enable)
        preQ <= '0;
      else if (stateQ == ST_RUN && enable)
        preQ <= (preQ == PRE_LAST) ? '0 : preQ + 1'b1;
    end
  end

  always_comb begin
    ctl.reloadCnt = (stateQ == ST_IDLE) && enable;
    ctl.modWrite  = modWe;
    ctl.loadWrite = modWe && enable;
    ctl.tick      = (stateQ == ST_RUN) && enable && (preQ == PRE_LAST);
  end

  // R4
  armed_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ARMED && enable && !syncPulse) |=> (stateQ == ST_ARMED));
  // R1
  armed_pre_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ARMED) |-> (preQ == '0));
  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.tick |=> !ctl.tick);
endmodule

// File: rtl/srcDatapath.sv
`timescale 1ns/1ps
module srcDatapath
  import srcPkg::*;
#(
  parameter int MOD_MIN = 9,
  parameter int MOD_MAX = 127,
  parameter int DATA_W  = 8,
  localparam int CNT_W  = $clog2(MOD_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] modData,
  output logic [CNT_W-1:0]  sampleCount,
  output logic              sampleStrobe
);
  logic [CNT_W-1:0] modQ, cntQ, clampVal;
  logic             strobeQ;

  function automatic logic [CNT_W-1:0] clampMod(input logic [DATA_W-1:0] v);
    if (v < DATA_W'(MOD_MIN))      return CNT_W'(MOD_MIN);
    else if (v > DATA_W'(MOD_MAX)) return CNT_W'(MOD_MAX);
    else                           return CNT_W'(v);
  endfunction

  assign clampVal = clampMod(modData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modQ    <= CNT_W'(MOD_MIN);
      cntQ    <= '0;
      strobeQ <= 1'b0;
    end else begin
      if (ctl.modWrite) modQ <= clampVal;
      strobeQ <= ctl.tick && (cntQ == CNT_W'(1));
      if (ctl.loadWrite)
        cntQ <= clampVal;
      else if (ctl.reloadCnt)
        cntQ <= modQ;
      else if (ctl.tick)
        cntQ <= (cntQ == CNT_W'(1)) ? modQ : cntQ - 1'b1;
    end
  end

  assign sampleCount  = cntQ;
  assign sampleStrobe = strobeQ;

  // R2
  mod_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modQ >= CNT_W'(MOD_MIN)) && (modQ <= CNT_W'(MOD_MAX)));
  // R5
  strobe_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleStrobe) |-> ($past(cntQ) == CNT_W'(1)));
  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe);
  // R6
  write_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWrite |=> (cntQ == $past(clampVal)));
  // R3
  enable_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.reloadCnt && !ctl.loadWrite) |=> (cntQ == $past(modQ)));
  // R5
  tick_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.tick |-> (cntQ != '0));
endmodule

// File: rtl/sampleRateCounter.sv
`timescale 1ns/1ps
module sampleRateCounter
  import srcPkg::*;
#(
  parameter int MOD_MIN  = 9,
  parameter int MOD_MAX  = 127,
  parameter int PRESCALE = 32,
  parameter int DATA_W   = 8,
  localparam int CNT_W   = $clog2(MOD_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              syncPulse,
  input  logic              modWe,
  input  logic [DATA_W-1:0] modData,
  output logic [CNT_W-1:0]  sampleCount,
  output logic              sampleStrobe
);
  ctlStrobes_t ctl;

  srcCtrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .syncPulse(syncPulse),
    .modWe(modWe), .ctl(ctl)
  );

  srcDatapath #(.MOD_MIN(MOD_MIN), .MOD_MAX(MOD_MAX), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .modData(modData),
    .sampleCount(sampleCount), .sampleStrobe(sampleStrobe)
  );

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sampleStrobe);
  // R7
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(sampleCount));
endmodule

// File: tb/test_sampleRateCounter.sv
`timescale 1ns/1ps
module test_sampleRateCounter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, syncPulse = 1'b0, modWe = 1'b0;
  logic [7:0] modData = '0;
  logic [6:0] sampleCount;
  logic sampleStrobe;
  logic tEnable = 1'b0, tSync = 1'b0, tWe = 1'b0;
  logic [7:0] tData = '0;
  logic [6:0] tCount;
  logic tStrobe;

  int vectors = 0, misc = 0;
  int aMod, expCnt, aEdge;

  always #4 clk = ~clk;

  sampleRateCounter #(.MOD_MIN(9)) i_sampleRateCounter (
    .clk(clk), .rstN(rstN), .enable(enable), .syncPulse(syncPulse),
    .modWe(modWe), .modData(modData), .sampleCount(sampleCount),
    .sampleStrobe(sampleStrobe));

  sampleRateCounter #(.MOD_MIN(16)) i_sampleRateCounter_tel (
    .clk(clk), .rstN(rstN), .enable(tEnable), .syncPulse(tSync),
    .modWe(tWe), .modData(tData), .sampleCount(tCount),
    .sampleStrobe(tStrobe));

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misc++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampB(input int v, input int lo);
    return (v < lo) ? lo : ((v > 127) ? 127 : v);
  endfunction

  // Runs the audio channel for a number of edges against a bench model.
  task automatic runAudio(input int edges, input int wrAt, input int wrVal, input int syncAt);
    for (int k = 0; k < edges; k++) begin
      bit tk, strb;
      modWe = (k == wrAt);
      modData = 8'(wrVal);
      syncPulse = (k == syncAt);
      @(posedge clk);
      aEdge++;
      tk = (aEdge % 32 == 0);
      strb = 0;
      if (k == wrAt) begin
        if (tk && expCnt == 1) strb = 1;
        aMod = clampB(wrVal, 9);
        expCnt = aMod;
      end else if (tk) begin
        if (expCnt == 1) begin strb = 1; expCnt = aMod; end
        else expCnt--;
      end
      @(negedge clk);
      check("R5 strobe", sampleStrobe, strb);
      check("R1/R6 count", sampleCount, expCnt);
    end
    modWe = 0; syncPulse = 0;
  endtask

  task automatic syncStart;
    syncPulse = 1;
    @(negedge clk);
    syncPulse = 0;
    aEdge = 0;
    expCnt = aMod;
    check("R4 count at sync", sampleCount, aMod);
  endtask

  task automatic startAudio(input int m);
    enable = 0;
    repeat (2) @(negedge clk);
    modWe = 1; modData = 8'(m);
    @(negedge clk);
    modWe = 0;
    aMod = clampB(m, 9);
    enable = 1;
    @(negedge clk);
    check("R3 reload on enable", sampleCount, aMod);
    syncStart();
  endtask

  task automatic testReset;
    check("R8 strobe", sampleStrobe, 0);
    check("R8 count", sampleCount, 0);
    check("R8 tel count", tCount, 0);
  endtask

  task automatic testArm;
    modWe = 1; modData = 8'd2;
    @(negedge clk);
    modWe = 0;
    check("R7 write while disabled holds count", sampleCount, 0);
    aMod = 9;
    enable = 1; syncPulse = 1;
    @(negedge clk);
    syncPulse = 0;
    check("R2/R3 clamped reload", sampleCount, 9);
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      check("R4 armed count", sampleCount, 9);
      check("R4 armed strobe", sampleStrobe, 0);
    end
    syncStart();
  endtask

  task automatic testRun;
    runAudio(9 * 32 * 2 + 5, -1, 0, 100);
  endtask

  task automatic testWrites;
    runAudio(12 * 32 + 64, 0, 12, -1);
    runAudio(40, 0, 200, -1);
  endtask

  task automatic testCollision;
    startAudio(9);
    runAudio(9 * 32 + 10 * 32 * 2, 9 * 32 - 1, 10, -1);
  endtask

  task automatic testDisable;
    int held;
    runAudio(100, -1, 0, -1);
    held = expCnt;
    enable = 0;
    for (int k = 0; k < 300; k++) begin
      syncPulse = (k % 50 == 3);
      @(negedge clk);
      check("R7 held count", sampleCount, held);
      check("R7 no strobe", sampleStrobe, 0);
    end
    syncPulse = 0;
    enable = 1;
    @(negedge clk);
    check("R3 re-enable reload", sampleCount, aMod);
    syncStart();
    runAudio(aMod * 32 + 4, -1, 0, -1);
  endtask

  task automatic testTelecom;
    int first = -1, second = -1;
    tEnable = 1;
    @(negedge clk);
    check("R8 tel reset modulus", tCount, 16);
    tEnable = 0; @(negedge clk);
    tWe = 1; tData = 8'd250; @(negedge clk); tWe = 0;
    tEnable = 1; @(negedge clk);
    check("R2 tel upper clamp", tCount, 127);
    tEnable = 0; @(negedge clk);
    tWe = 1; tData = 8'd10; @(negedge clk); tWe = 0;
    tEnable = 1; @(negedge clk);
    check("R2 tel lower clamp", tCount, 16);
    tEnable = 0; @(negedge clk);
    tWe = 1; tData = 8'd40; @(negedge clk); tWe = 0;
    tEnable = 1; @(negedge clk);
    tSync = 1; @(negedge clk); tSync = 0;
    check("R9 tel start count", tCount, 40);
    for (int k = 1; k <= 2600; k++) begin
      @(negedge clk);
      if (tStrobe) begin
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
    end
    check("R9 first strobe edge", first, 1280);
    check("R9 strobe spacing", second - first, 1280);
  endtask

  initial begin
    #(8 * 150000);
    misc++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misc);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testArm();
    testRun();
    testWrites();
    testCollision();
    testDisable();
    testTelecom();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misc);
    $finish;
  end
endmodule